// File: doc/BRIEF.md
# Macro-Op Dispatch Splitter

This block sits between instruction decode and the integer schedulers. Each cycle it takes a group of up to two macro-ops. Each macro-op carries a three-bit kind code, an age tag and a payload. The block breaks every macro-op into its micro-ops. Arithmetic work goes to the write lanes of the arithmetic scheduler queue. Loads and stores go to the write lanes of the address-generation scheduler queue. A single macro-op may therefore feed both queues at once, and a combined load-and-store macro-op yields two address-generation entries.

The arithmetic queue holds 20 entries and the address queue holds 12. Both report their current free count. The block compares the micro-op demand of the whole group against the room left in each queue. It accepts the group only if everything fits in both queues, and otherwise holds off the entire group. Accepted micro-ops are registered and presented on packed write lanes in the following cycle. Each micro-op keeps the age tag and payload of the macro-op it came from, so that later stages can order them.

Top module: `mop_dispatch_split`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, no write-enable lane of either queue is active.
- R2: Kind bit 0 yields one arithmetic micro-op, kind bit 1 yields one load micro-op and kind bit 2 yields one store micro-op. Any combination of the three bits may be set, and load and store micro-ops both go to the address queue.
- R3: The micro-ops of a group accepted in cycle N appear on the write lanes in cycle N+1 and only then. An arithmetic lane carries {age, payload}. An address lane carries {store flag, age, payload}, with the store flag as MSB set to 1 for a store and 0 for a load.
- R4: in_ready is high exactly when the group's arithmetic demand fits the arithmetic room and the group's address demand fits the address room. When in_ready is low, no micro-op of that cycle's group is ever written.
- R5: The room in each queue is its reported free count minus the number of that queue's write lanes currently active at the outputs, floored at zero.
- R6: Write lanes fill from lane 0 upward without gaps. Slot 0 is the older macro-op, and its micro-ops come before those of slot 1 in each queue. Within one macro-op the load comes before the store.
- R7: A valid macro-op with kind 000 produces no micro-op and needs no room.
- R8: Either slot may be valid on its own. A cycle with no valid slot produces no writes.
- R9: The age tag and payload of each micro-op equal those of its parent macro-op.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 2 | Valid per macro-op slot; slot 0 is older |
| in_kind | input | 6 | Three-bit kind code per slot (bit0 ALU, bit1 load, bit2 store) |
| in_age | input | 12 | Six-bit age tag per slot |
| in_payload | input | 32 | Sixteen-bit payload per slot |
| alu_free | input | 5 | Free entries reported by the arithmetic queue |
| agu_free | input | 4 | Free entries reported by the address queue |
| in_ready | output | 1 | The present group fits and is taken at the clock edge |
| alu_wr_en | output | 2 | Write enable per arithmetic lane |
| alu_wr_data | output | 44 | 22-bit micro-op per arithmetic lane |
| agu_wr_en | output | 4 | Write enable per address lane |
| agu_wr_data | output | 92 | 23-bit micro-op per address lane |

## Verification
in_ready is combinational, so its value is due in the same cycle that the group is driven. The bench samples it one nanosecond after changing the inputs on the falling edge. The write lanes come out of a single register stage and are due in the cycle after acceptance. The bench samples them one nanosecond after the next rising edge and compares them with a queue-based reference model. That model also carries the active lane counts forward as the pending deduction for the next cycle's room check. Data are compared only on lanes the model expects to be enabled.

// File: rtl/mds_pkg.sv
package mds_pkg;
  localparam int SLOTS     = 2;
  localparam int KIND_W    = 3;
  localparam int AGE_W     = 6;
  localparam int PAY_W     = 16;
  localparam int ALU_DEPTH = 20;
  localparam int AGU_DEPTH = 12;

  localparam int KB_ALU = 0;
  localparam int KB_LD  = 1;
  localparam int KB_ST  = 2;

  localparam int ALU_UW    = AGE_W + PAY_W;
  localparam int AGU_UW    = 1 + AGE_W + PAY_W;
  localparam int ALU_LANES = SLOTS;
  localparam int AGU_LANES = 2 * SLOTS;
  localparam int ALU_CW    = $clog2(ALU_DEPTH + 1);
  localparam int AGU_CW    = $clog2(AGU_DEPTH + 1);
  localparam int ALU_NW    = $clog2(ALU_LANES + 1);
  localparam int AGU_NW    = $clog2(AGU_LANES + 1);
endpackage

// File: rtl/mds_slot_split.sv
module mds_slot_split
  import mds_pkg::*;
(
  input  logic              valid,
  input  logic [KIND_W-1:0] kind,
  input  logic [AGE_W-1:0]  age,
  input  logic [PAY_W-1:0]  payload,
  output logic              alu_v,
  output logic [ALU_UW-1:0] alu_d,
  output logic              ld_v,
  output logic [AGU_UW-1:0] ld_d,
  output logic              st_v,
  output logic [AGU_UW-1:0] st_d
);
  // R2: each kind bit selects one micro-op; R9: age and payload pass through
  always_comb begin
    alu_v = valid & kind[KB_ALU];
    ld_v  = valid & kind[KB_LD];
    st_v  = valid & kind[KB_ST];
    alu_d = {age, payload};
    ld_d  = {1'b0, age, payload};
    st_d  = {1'b1, age, payload};
  end
endmodule

// File: rtl/mds_lane_pack.sv
module mds_lane_pack #(
  parameter int N  = 2,
  parameter int W  = 8,
  parameter int CW = 2
) (
  input  logic [N-1:0]   src_v,
  input  logic [N*W-1:0] src_d,
  output logic [N-1:0]   dst_v,
  output logic [N*W-1:0] dst_d,
  output logic [CW-1:0]  cnt
);
  // R6: sources arrive oldest first; compact them onto the lowest lanes
  always_comb begin
    int pos;
    pos   = 0;
    dst_v = '0;
    dst_d = '0;
    for (int i = 0; i < N; i++) begin
      if (src_v[i]) begin
        dst_v[pos]         = 1'b1;
        dst_d[pos*W +: W]  = src_d[i*W +: W];
        pos                = pos + 1;
      end
    end
    cnt = CW'(pos);
  end
endmodule

// File: rtl/mds_credit_gate.sv
module mds_credit_gate #(
  parameter int LANES = 2,
  parameter int CW    = 5,
  parameter int NW    = 2
) (
  input  logic [CW-1:0]    free_cnt,
  input  logic [LANES-1:0] pend_en,
  input  logic [NW-1:0]    need,
  output logic             fits
);
  logic [CW-1:0] pend;
  logic [CW-1:0] room;

  // R5: writes still on the output lanes are not yet in the reported count
  always_comb begin
    pend = '0;
    for (int i = 0; i < LANES; i++) pend = pend + CW'(pend_en[i]);
    room = (free_cnt > pend) ? (free_cnt - pend) : '0;
    fits = (CW'(need) <= room);
  end
endmodule

// File: rtl/mop_dispatch_split.sv
module mop_dispatch_split
  import mds_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [SLOTS-1:0]            in_valid,
  input  logic [SLOTS*KIND_W-1:0]     in_kind,
  input  logic [SLOTS*AGE_W-1:0]      in_age,
  input  logic [SLOTS*PAY_W-1:0]      in_payload,
  input  logic [ALU_CW-1:0]           alu_free,
  input  logic [AGU_CW-1:0]           agu_free,
  output logic                        in_ready,
  output logic [ALU_LANES-1:0]        alu_wr_en,
  output logic [ALU_LANES*ALU_UW-1:0] alu_wr_data,
  output logic [AGU_LANES-1:0]        agu_wr_en,
  output logic [AGU_LANES*AGU_UW-1:0] agu_wr_data
);
  logic [ALU_LANES-1:0]        alu_src_v;
  logic [ALU_LANES*ALU_UW-1:0] alu_src_d;
  logic [AGU_LANES-1:0]        agu_src_v;
  logic [AGU_LANES*AGU_UW-1:0] agu_src_d;

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    mds_slot_split i_split (
      .valid   (in_valid[s]),
      .kind    (in_kind[s*KIND_W +: KIND_W]),
      .age     (in_age[s*AGE_W +: AGE_W]),
      .payload (in_payload[s*PAY_W +: PAY_W]),
      .alu_v   (alu_src_v[s]),
      .alu_d   (alu_src_d[s*ALU_UW +: ALU_UW]),
      .ld_v    (agu_src_v[2*s]),
      .ld_d    (agu_src_d[(2*s)*AGU_UW +: AGU_UW]),
      .st_v    (agu_src_v[2*s+1]),
      .st_d    (agu_src_d[(2*s+1)*AGU_UW +: AGU_UW])
    );
  end

  logic [ALU_LANES-1:0]        alu_pk_v;
  logic [ALU_LANES*ALU_UW-1:0] alu_pk_d;
  logic [ALU_NW-1:0]           alu_need;
  logic [AGU_LANES-1:0]        agu_pk_v;
  logic [AGU_LANES*AGU_UW-1:0] agu_pk_d;
  logic [AGU_NW-1:0]           agu_need;

  mds_lane_pack #(.N(ALU_LANES), .W(ALU_UW), .CW(ALU_NW)) i_alu_pack (
    .src_v (alu_src_v), .src_d (alu_src_d),
    .dst_v (alu_pk_v),  .dst_d (alu_pk_d), .cnt (alu_need)
  );

  mds_lane_pack #(.N(AGU_LANES), .W(AGU_UW), .CW(AGU_NW)) i_agu_pack (
    .src_v (agu_src_v), .src_d (agu_src_d),
    .dst_v (agu_pk_v),  .dst_d (agu_pk_d), .cnt (agu_need)
  );

  logic alu_fits, agu_fits;

  mds_credit_gate #(.LANES(ALU_LANES), .CW(ALU_CW), .NW(ALU_NW)) i_alu_gate (
    .free_cnt (alu_free), .pend_en (alu_wr_en), .need (alu_need), .fits (alu_fits)
  );

  mds_credit_gate #(.LANES(AGU_LANES), .CW(AGU_CW), .NW(AGU_NW)) i_agu_gate (
    .free_cnt (agu_free), .pend_en (agu_wr_en), .need (agu_need), .fits (agu_fits)
  );

  // R4: the group moves as a whole or not at all
  logic accept;
  logic [ALU_LANES-1:0] alu_en_d;
  logic [AGU_LANES-1:0] agu_en_d;

  always_comb begin
    in_ready = alu_fits & agu_fits;
    accept   = in_ready & (|in_valid);
    alu_en_d = accept ? alu_pk_v : '0;
    agu_en_d = accept ? agu_pk_v : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alu_wr_en <= '0;
      agu_wr_en <= '0;
    end else begin
      alu_wr_en <= alu_en_d;
      agu_wr_en <= agu_en_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alu_wr_data <= '0;
      agu_wr_data <= '0;
    end else if (accept) begin
      alu_wr_data <= alu_pk_d;
      agu_wr_data <= agu_pk_d;
    end
  end

  p_stall_no_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((|in_valid) && !in_ready) |=> (alu_wr_en == '0 && agu_wr_en == '0));

  p_alu_room_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|alu_wr_en) |-> ($countones(alu_wr_en) <= int'($past(alu_free))));

  p_agu_room_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|agu_wr_en) |-> ($countones(agu_wr_en) <= int'($past(agu_free))));

  p_alu_packed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((alu_wr_en & (alu_wr_en + 1'b1)) == '0));

  p_agu_packed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((agu_wr_en & (agu_wr_en + 1'b1)) == '0));

  p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid == '0) |=> (alu_wr_en == '0 && agu_wr_en == '0));

  p_agu_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(agu_wr_en) <= 2 * $countones($past(in_valid)));
endmodule

// File: tb/test_mop_dispatch_split.sv
module test_mop_dispatch_split;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  in_valid;
  logic [5:0]  in_kind;
  logic [11:0] in_age;
  logic [31:0] in_payload;
  logic [4:0]  alu_free;
  logic [3:0]  agu_free;
  logic        in_ready;
  logic [1:0]  alu_wr_en;
  logic [43:0] alu_wr_data;
  logic [3:0]  agu_wr_en;
  logic [91:0] agu_wr_data;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  int pend_alu = 0;
  int pend_agu = 0;

  always #2 clk = ~clk;

  mop_dispatch_split i_mop_dispatch_split (
    .clk, .rst_n, .in_valid, .in_kind, .in_age, .in_payload,
    .alu_free, .agu_free, .in_ready, .alu_wr_en, .alu_wr_data,
    .agu_wr_en, .agu_wr_data
  );

  task automatic check(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] v, input logic [2:0] k0, input logic [2:0] k1,
                      input logic [5:0] a0, input logic [5:0] a1,
                      input logic [15:0] p0, input logic [15:0] p1,
                      input int af, input int gf, input string tag);
    logic [21:0] aq[$];
    logic [22:0] gq[$];
    logic [2:0]  k[2];
    logic [5:0]  a[2];
    logic [15:0] p[2];
    int ra, rg;
    bit exp_rdy, acc;
    k[0] = k0; k[1] = k1; a[0] = a0; a[1] = a1; p[0] = p0; p[1] = p1;
    for (int s = 0; s < 2; s++) begin
      if (v[s]) begin
        if (k[s][0]) aq.push_back({a[s], p[s]});
        if (k[s][1]) gq.push_back({1'b0, a[s], p[s]});
        if (k[s][2]) gq.push_back({1'b1, a[s], p[s]});
      end
    end
    ra = (af > pend_alu) ? af - pend_alu : 0;
    rg = (gf > pend_agu) ? gf - pend_agu : 0;
    exp_rdy = (aq.size() <= ra) && (gq.size() <= rg);
    acc = exp_rdy && (v != 2'b00);
    @(negedge clk);
    in_valid   = v;
    in_kind    = {k1, k0};
    in_age     = {a1, a0};
    in_payload = {p1, p0};
    alu_free   = 5'(af);
    agu_free   = 4'(gf);
    #1;
    check({"R4 R5 ready ", tag}, 128'(in_ready), 128'(exp_rdy));
    @(posedge clk);
    #1;
    in_valid = 2'b00;
    if (acc) begin
      check({"R2 R6 R7 R8 alu lanes ", tag}, 128'(alu_wr_en), 128'((1 << aq.size()) - 1));
      check({"R2 R6 R7 R8 agu lanes ", tag}, 128'(agu_wr_en), 128'((1 << gq.size()) - 1));
      for (int i = 0; i < aq.size(); i++)
        check({"R3 R9 alu data ", tag}, 128'(alu_wr_data[i*22 +: 22]), 128'(aq[i]));
      for (int i = 0; i < gq.size(); i++)
        check({"R3 R6 R9 agu data ", tag}, 128'(agu_wr_data[i*23 +: 23]), 128'(gq[i]));
      pend_alu = aq.size();
      pend_agu = gq.size();
    end else begin
      check({"R4 R8 alu stall ", tag}, 128'(alu_wr_en), 128'(0));
      check({"R4 R8 agu stall ", tag}, 128'(agu_wr_en), 128'(0));
      pend_alu = 0;
      pend_agu = 0;
    end
  endtask

  initial begin
    #800000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    in_valid = '0; in_kind = '0; in_age = '0; in_payload = '0;
    alu_free = 5'd20; agu_free = 4'd12;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset alu", 128'(alu_wr_en), 128'(0));
    check("R1 reset agu", 128'(agu_wr_en), 128'(0));
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    check("R1 after release", 128'({alu_wr_en, agu_wr_en}), 128'(0));
    // directed cases
    step(2'b01, 3'b001, 3'b000, 6'd1, 6'd2, 16'hA001, 16'h0, 20, 12, "R2 single alu");
    step(2'b11, 3'b111, 3'b111, 6'd3, 6'd4, 16'hB003, 16'hB004, 20, 12, "R6 both full");
    step(2'b11, 3'b110, 3'b011, 6'd5, 6'd6, 16'hC005, 16'hC006, 12, 8, "R5 pending deduct");
    step(2'b00, 3'b000, 3'b000, 6'd0, 6'd0, 16'h0, 16'h0, 20, 12, "R8 idle");
    step(2'b11, 3'b001, 3'b001, 6'd7, 6'd8, 16'hD007, 16'hD008, 1, 12, "R4 alu short");
    step(2'b11, 3'b001, 3'b001, 6'd7, 6'd8, 16'hD007, 16'hD008, 2, 12, "R4 alu exact");
    step(2'b00, 3'b000, 3'b000, 6'd0, 6'd0, 16'h0, 16'h0, 20, 12, "R8 idle2");
    step(2'b11, 3'b110, 3'b110, 6'd9, 6'd10, 16'hE009, 16'hE00A, 20, 3, "R4 agu short");
    step(2'b11, 3'b110, 3'b110, 6'd9, 6'd10, 16'hE009, 16'hE00A, 20, 4, "R4 agu exact");
    step(2'b11, 3'b000, 3'b000, 6'd11, 6'd12, 16'h1, 16'h2, 0, 0, "R7 kind zero");
    step(2'b10, 3'b000, 3'b101, 6'd13, 6'd14, 16'h3, 16'hF00E, 20, 12, "R8 slot1 only");
    step(2'b11, 3'b100, 3'b010, 6'd15, 6'd16, 16'h4, 16'h5, 20, 12, "R6 store then load");
    for (int n = 0; n < 400; n++) begin
      step(2'($urandom_range(0, 3)), 3'($urandom_range(0, 7)), 3'($urandom_range(0, 7)),
           6'($urandom), 6'($urandom), 16'($urandom), 16'($urandom),
           $urandom_range(0, 20), $urandom_range(0, 12), "random");
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule